// File: doc/BRIEF.md
# Clock Output Enable Controller

This block sits between one free-running reference clock and a bank of output clock channels (nine by default). It decides, channel by channel, whether the reference clock is passed through, and it makes every start and stop glitch-free: an output never shows a shortened or stretched high phase, and a stopped output always rests low. A channel runs only when its enable pin and its configuration enable bit are both high. The bits come from a configuration interface outside this block.

A single shared input pin has two roles. After reset it acts as a power-good indication. While it stays low, every output is held off, but the oscillator-enable and configuration-enable indications stay asserted. The first time the pin is seen high it becomes a power-down control, and it keeps that role until the next reset. A low level in that role puts the block in standby: all outputs stop low and both enable indications drop. A later rising edge restarts the outputs within a bounded number of reference cycles. The block also reports whether down-spread was requested. The spread-select input is captured once, when the block leaves its power-good phase.

Top module: `clk_oe_ctrl`

## Requirements
- R1: After reset, while the shared pin has not yet been seen high, every output stays low, `standby` is 0, and `osc_en` and `cfg_en` are both 1.
- R2: The first high level on the shared pin leaves the power-good phase. Enabled outputs then toggle once per reference cycle.
- R3: Once the pin has left the power-good phase, a low level on it enters standby. `standby` becomes 1, `osc_en` and `cfg_en` become 0, and every output stays low.
- R4: A rising edge on the shared pin while in standby clears `standby`. The first output high phase then appears within 2 to 6 reference rising edges of the pin edge.
- R5: Output bit i runs only when `oe_pin[i]` and `oe_reg[i]` are both 1. If either is 0, that output stays low.
- R6: Every output high phase is exactly half a reference period long. A disabled output rests low, including while the reference clock is high.
- R7: When a disabled output is enabled again through either of its enable inputs, its first high phase appears within 2 to 6 reference rising edges.
- R8: Changing one channel's enables leaves the pulse count of every other channel unchanged.
- R9: `spread_on` takes the value of `spread_sel` when the power-good phase ends. Later changes of `spread_sel`, including changes across standby entry and exit, do not alter it.
- R10: The power-down role of the pin is permanent until reset. A second low level leads to standby (`osc_en` = 0), not back to the power-good phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pg_pd_pin | input | 1 | Shared power-good / power-down pin, asynchronous |
| oe_pin | input | N_OUT | Per-channel enable pins, active high, asynchronous |
| oe_reg | input | N_OUT | Per-channel configuration enable bits |
| spread_sel | input | 1 | Down-spread request, 1 = -0.5 % spread |
| clk_out | output | N_OUT | Gated output clocks |
| standby | output | 1 | 1 while in standby |
| osc_en | output | 1 | Oscillator should run |
| cfg_en | output | 1 | Configuration logic should run |
| spread_on | output | 1 | Latched spread request |

## Verification
The bench sweeps a set of enable patterns across both the pin and register vectors and counts output pulses on every channel in a fixed window. A design that combined the two enables with OR, or let one channel's gate disturb another, would show the wrong counts. Every high phase is timed, so a gate that switched while the clock was high would produce a short pulse and be caught. Start-up latency is measured on the pin path, on the register path and on standby exit, which catches a missing or extra synchronizer stage. The pin's role is probed on both sides of the first high level and again after a second low, so a state machine that fell back into the power-good phase would leave `osc_en` high where it must drop. Flipping `spread_sel` after latching, and across a standby cycle, exposes a latch that follows its input.

// File: rtl/clk_oe_pkg.sv
package clk_oe_pkg;
  typedef enum logic [1:0] {
    PM_GOOD_WAIT = 2'd0,
    PM_RUN       = 2'd1,
    PM_STANDBY   = 2'd2
  } pin_mode_e;
endpackage

// File: rtl/sync_2ff.sv
module sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pin_mode_fsm.sv
module pin_mode_fsm
  import clk_oe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic pin_s,
  input  logic spread_s,
  output logic run,
  output logic standby,
  output logic osc_en,
  output logic cfg_en,
  output logic spread_on
);
  pin_mode_e state_q, state_d;
  logic      spread_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_GOOD_WAIT: if (pin_s)  state_d = PM_RUN;
      PM_RUN:       if (!pin_s) state_d = PM_STANDBY;
      PM_STANDBY:   if (pin_s)  state_d = PM_RUN;
      default:                  state_d = PM_GOOD_WAIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PM_GOOD_WAIT;
      spread_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == PM_GOOD_WAIT && pin_s) spread_q <= spread_s;
    end
  end

  assign run       = (state_q == PM_RUN);
  assign standby   = (state_q == PM_STANDBY);
  assign osc_en    = (state_q != PM_STANDBY);
  assign cfg_en    = (state_q != PM_STANDBY);
  assign spread_on = spread_q;

  // R10
  mode_never_returns_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != PM_GOOD_WAIT) |=> (state_q != PM_GOOD_WAIT));

  // R9
  spread_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != PM_GOOD_WAIT) |=> $stable(spread_q));

  // R3
  pd_low_enters_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_RUN && !pin_s) |=> (state_q == PM_STANDBY));

  // R4
  standby_exit_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PM_STANDBY && pin_s) |=> (state_q == PM_RUN));
endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic gate_q,
  output logic clk_o
);
  // Gate state moves only on the falling edge, while the clock is low.
  always_ff @(negedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= en;
  end

  assign clk_o = clk & gate_q;

  // R5
  gate_follows_en_chk: assert property (@(posedge clk) disable iff (rst)
    gate_q == en);
endmodule

// File: rtl/clk_oe_ctrl.sv
module clk_oe_ctrl #(
  parameter int N_OUT = 9
) (
  input  logic             clk_ref,
  input  logic             rst,
  input  logic             pg_pd_pin,
  input  logic [N_OUT-1:0] oe_pin,
  input  logic [N_OUT-1:0] oe_reg,
  input  logic             spread_sel,
  output logic [N_OUT-1:0] clk_out,
  output logic             standby,
  output logic             osc_en,
  output logic             cfg_en,
  output logic             spread_on
);
  localparam int SYNC_W = 2 * N_OUT + 2;

  logic [SYNC_W-1:0] sync_d, sync_q;
  logic [N_OUT-1:0]  pin_s, reg_s, gate_vec;
  logic              pg_s, spread_s, run;

  assign sync_d = {spread_sel, pg_pd_pin, oe_reg, oe_pin};

  sync_2ff #(.W(SYNC_W)) u_sync (
    .clk (clk_ref),
    .rst (rst),
    .d   (sync_d),
    .q   (sync_q)
  );

  assign pin_s    = sync_q[N_OUT-1:0];
  assign reg_s    = sync_q[2*N_OUT-1:N_OUT];
  assign pg_s     = sync_q[2*N_OUT];
  assign spread_s = sync_q[2*N_OUT+1];

  pin_mode_fsm u_fsm (
    .clk       (clk_ref),
    .rst       (rst),
    .pin_s     (pg_s),
    .spread_s  (spread_s),
    .run       (run),
    .standby   (standby),
    .osc_en    (osc_en),
    .cfg_en    (cfg_en),
    .spread_on (spread_on)
  );

  for (genvar g = 0; g < N_OUT; g++) begin : g_chan
    logic chan_en;
    assign chan_en = run & pin_s[g] & reg_s[g];

    clk_gate_cell u_gate (
      .clk    (clk_ref),
      .rst    (rst),
      .en     (chan_en),
      .gate_q (gate_vec[g]),
      .clk_o  (clk_out[g])
    );
  end

  // R3
  standby_gates_off_chk: assert property (@(posedge clk_ref) disable iff (rst)
    standby |-> (gate_vec == '0));

  // R1
  wait_osc_on_chk: assert property (@(posedge clk_ref) disable iff (rst)
    (!standby && !run) |-> (osc_en && cfg_en && gate_vec == '0));
endmodule

// File: tb/clk_oe_ctrl_tb.sv
`timescale 1ns/1ps
module clk_oe_ctrl_tb;
  localparam int N = 9;
  localparam int WIN = 8;

  logic         clk_ref = 1'b0;
  logic         rst = 1'b1;
  logic         pg_pd_pin = 1'b0;
  logic [N-1:0] oe_pin = '1;
  logic [N-1:0] oe_reg = '1;
  logic         spread_sel = 1'b1;
  logic [N-1:0] clk_out;
  logic         standby, osc_en, cfg_en, spread_on;

  int total = 0;
  int bad = 0;
  int pulse_cnt [N];
  int glitch_cnt [N];

  always #10 clk_ref = ~clk_ref;

  clk_oe_ctrl #(.N_OUT(N)) u_dut (
    .clk_ref(clk_ref), .rst(rst), .pg_pd_pin(pg_pd_pin),
    .oe_pin(oe_pin), .oe_reg(oe_reg), .spread_sel(spread_sel),
    .clk_out(clk_out), .standby(standby), .osc_en(osc_en),
    .cfg_en(cfg_en), .spread_on(spread_on)
  );

  for (genvar g = 0; g < N; g++) begin : g_mon
    realtime t_rise = 0.0;
    always @(posedge clk_out[g]) begin
      t_rise = $realtime;
      pulse_cnt[g] = pulse_cnt[g] + 1;
    end
    always @(negedge clk_out[g])
      if ($realtime - t_rise != 10.0) glitch_cnt[g] = glitch_cnt[g] + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_ref);
    #1;
  endtask

  task automatic count_window(output int c [N]);
    for (int i = 0; i < N; i++) pulse_cnt[i] = 0;
    cycles(WIN);
    for (int i = 0; i < N; i++) c[i] = pulse_cnt[i];
  endtask

  // Posedges from now until channel ch first goes high (capped at 20).
  task automatic latency(input int ch, output int n);
    n = 0;
    while (n < 20) begin
      @(posedge clk_ref);
      n++;
      #1;
      if (clk_out[ch]) break;
    end
  endtask

  task automatic check_range(input string req, input int v);
    total++;
    if (v < 2 || v > 6) begin
      bad++;
      $display("FAIL %s actual=%0d expected=2..6", req, v);
    end
  endtask

  initial begin : watchdog
    #2000000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int c [N];
    int lat;
    logic [N-1:0] pp, rp, both;
    for (int i = 0; i < N; i++) begin pulse_cnt[i] = 0; glitch_cnt[i] = 0; end

    cycles(4);
    rst = 1'b0;
    cycles(6);
    // R1: power-good phase
    check("R1 standby", int'(standby), 0);
    check("R1 osc_en", int'(osc_en), 1);
    check("R1 cfg_en", int'(cfg_en), 1);
    count_window(c);
    for (int i = 0; i < N; i++) check("R1 no pulses", c[i], 0);

    // R2: first high leaves power-good phase
    @(negedge clk_ref); #1;
    pg_pd_pin = 1'b1;
    latency(0, lat);
    check_range("R4 first start latency", lat);
    cycles(4);
    count_window(c);
    for (int i = 0; i < N; i++) check("R2 running", c[i], WIN);
    check("R9 spread latched", int'(spread_on), 1);

    // R9: later changes ignored
    spread_sel = 1'b0;
    cycles(6);
    check("R9 spread held", int'(spread_on), 1);

    // R5 / R8 / R6: enable pattern sweep
    for (int k = 0; k < 24; k++) begin
      pp = N'((k * 173 + 5) % (1 << N));
      rp = N'((k * 301 + 77) % (1 << N));
      if (k == 0) begin pp = '1; rp = '0; end
      if (k == 1) begin pp = '0; rp = '1; end
      if (k == 2) begin pp = '1; rp = '1; end
      oe_pin = pp;
      oe_reg = rp;
      both = pp & rp;
      cycles(6);
      count_window(c);
      for (int i = 0; i < N; i++)
        check("R5 R8 channel pulses", c[i], both[i] ? WIN : 0);
      @(posedge clk_ref); #2;
      check("R6 high-phase level", int'(clk_out), int'(both));
      cycles(1);
    end

    // R7: re-enable via register bit, then via pin
    oe_pin = '1; oe_reg = '1;
    cycles(6);
    oe_reg[3] = 1'b0;
    cycles(6);
    check("R6 stopped low", int'(clk_out[3]), 0);
    latency(4, lat);
    check("R8 neighbour unaffected", lat, 1);
    @(negedge clk_ref); #1;
    oe_reg[3] = 1'b1;
    latency(3, lat);
    check_range("R7 reg re-enable latency", lat);
    cycles(2);
    oe_pin[5] = 1'b0;
    cycles(6);
    oe_pin[5] = 1'b1;
    latency(5, lat);
    check_range("R7 pin re-enable latency", lat);
    cycles(4);

    // R3: standby
    pg_pd_pin = 1'b0;
    cycles(6);
    check("R3 standby", int'(standby), 1);
    check("R3 osc_en", int'(osc_en), 0);
    check("R3 cfg_en", int'(cfg_en), 0);
    count_window(c);
    for (int i = 0; i < N; i++) check("R3 no pulses", c[i], 0);
    spread_sel = 1'b0;

    // R4: exit standby
    @(negedge clk_ref); #1;
    pg_pd_pin = 1'b1;
    latency(2, lat);
    check_range("R4 exit latency", lat);
    cycles(4);
    check("R4 standby cleared", int'(standby), 0);
    count_window(c);
    for (int i = 0; i < N; i++) check("R4 running", c[i], WIN);
    check("R9 spread after standby", int'(spread_on), 1);

    // R10: second low goes to standby, not power-good phase
    pg_pd_pin = 1'b0;
    cycles(6);
    check("R10 osc_en", int'(osc_en), 0);
    check("R10 standby", int'(standby), 1);

    for (int i = 0; i < N; i++) check("R6 glitch count", glitch_cnt[i], 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule